// File: doc/BRIEF.md
# Core Clock Frequency Change Controller

This controller carries out a software-requested change of the core clock frequency. Software writes a new clock configuration word at any time. The word is only held as pending. A later control write sets the sticky change-request bit and starts a sequence. That write also selects turbo or normal run mode, and the low-speed idle mode.

The sequence has fixed steps. First it stops the CPU clock and gates interrupts. It then asks the memory side to put SDRAM into self-refresh and waits for the acknowledge. Next it loads the captured configuration into the PLL with a one-cycle program strobe. It waits a fixed lock time, set by a parameter, through a down-counter. After that it restarts the CPU clock in the mode that was requested. Last, it releases self-refresh and waits for the acknowledge to drop.

Entering or leaving the low-speed idle mode uses this same full sequence. A hardware or watchdog reset abandons the sequence at once and puts the PLL back to its reset word. A GPIO reset that arrives before the relock has finished keeps its reset-exit hold asserted until the PLL has relocked.

Top module: `freq_change_seq`

## Requirements
- R1: While `rst_n` is low and after it is released, the outputs are at their reset values. These are: `pll_cfg` = CFG_RST, `cpu_clk_en` = 1, `irq_gate` = 0, `sr_req` = 0, `fcs_flag` = 0, `turbo_mode` = 0, `slow_mode` = 0, `seq_done` = 0 and `pll_prog` = 0.
- R2: A configuration write alone changes neither `pll_cfg` nor the mode outputs. `pll_cfg` changes only in the cycle in which `pll_prog` is high. A configuration write made while a sequence is running does not affect the value that sequence programs.
- R3: A control write with `ctl_fcs` = 1 in the idle state starts a sequence. From the next cycle, `cpu_clk_en` = 0, `irq_gate` = 1 and `sr_req` = 1. `pll_prog` pulses exactly one cycle after the first cycle in which `sr_ack` is seen high.
- R4: Every sequence issues exactly one one-cycle `pll_prog` pulse. During that pulse, `pll_cfg` equals the configuration word that was pending at the start of the sequence. The pulse is issued even when that word equals the current `pll_cfg`.
- R5: `cpu_clk_en` returns to 1 exactly LOCK_CYC+1 cycles after the `pll_prog` cycle. At that moment, `turbo_mode` and `slow_mode` take the `ctl_turbo` and `ctl_slow` values of the starting control write, `irq_gate` returns to 0 and `sr_req` drops to 0.
- R6: `seq_done` is a one-cycle pulse. It comes one cycle after the first cycle in which `sr_ack` is seen low with the CPU clock running again. The controller is then idle.
- R7: `fcs_flag` takes the `ctl_fcs` value of every control write. Completing a sequence does not clear it. A control write with `ctl_fcs` = 0 starts no sequence.
- R8: `wdt_rst` high at a clock edge, or `rst_n` low at any time, abandons any sequence. It also restores all R1 values and resets the pending configuration to CFG_RST.
- R9: `rst_hold` is high whenever `gpio_rst` is high. If `gpio_rst` is seen high before the relock has finished, `rst_hold` stays high until `cpu_clk_en` returns to 1. Otherwise `rst_hold` equals `gpio_rst`.
- R10: A control write made while a sequence is running starts no second sequence, and its mode bits do not change the mode that the current sequence applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| wdt_rst | input | 1 | Synchronous watchdog reset |
| gpio_rst | input | 1 | GPIO reset request, level |
| cfg_wr_en | input | 1 | Configuration word write strobe |
| cfg_wr_data | input | CFG_W | Configuration word written |
| ctl_wr_en | input | 1 | Control write strobe |
| ctl_fcs | input | 1 | Change-request bit of the control write |
| ctl_turbo | input | 1 | Turbo select of the control write |
| ctl_slow | input | 1 | Low-speed idle select of the control write |
| fcs_flag | output | 1 | Sticky change-request bit |
| pll_prog | output | 1 | One-cycle PLL program strobe |
| pll_cfg | output | CFG_W | Configuration applied to the PLL |
| cpu_clk_en | output | 1 | CPU clock running |
| irq_gate | output | 1 | Interrupts to the CPU blocked |
| turbo_mode | output | 1 | CPU runs in turbo mode |
| slow_mode | output | 1 | Low-speed idle mode active |
| sr_req | output | 1 | SDRAM self-refresh request |
| sr_ack | input | 1 | SDRAM self-refresh acknowledge |
| seq_done | output | 1 | Sequence complete pulse |
| rst_hold | output | 1 | Reset-exit hold toward the chip |

## Verification
The assertions check the local rules on every cycle:
- The program strobe and the done pulse each last one cycle.
- The PLL is programmed only with the CPU clock stopped and self-refresh requested.
- `pll_cfg` moves only on a program strobe or after a watchdog reset.
- The request bit stays set when no control write occurs.
- The reset-exit hold follows the GPIO reset rule.

Only the bench scenarios can show the rest:
- The exact lock length, and the waits for the acknowledge.
- That the word programmed is the one captured at entry, over every configuration and mode value.
- That writes during a sequence are held back.
- That a GPIO reset stretches the hold across the relock.
- What state remains after a watchdog or hardware reset in the middle of a sequence.

// File: rtl/freq_change_seq.sv
module freq_change_seq #(
  parameter int               CFG_W    = 10,
  parameter logic [CFG_W-1:0] CFG_RST  = 'h121,
  parameter int               LOCK_CYC = 300
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wdt_rst,
  input  logic             gpio_rst,
  input  logic             cfg_wr_en,
  input  logic [CFG_W-1:0] cfg_wr_data,
  input  logic             ctl_wr_en,
  input  logic             ctl_fcs,
  input  logic             ctl_turbo,
  input  logic             ctl_slow,
  output logic             fcs_flag,
  output logic             pll_prog,
  output logic [CFG_W-1:0] pll_cfg,
  output logic             cpu_clk_en,
  output logic             irq_gate,
  output logic             turbo_mode,
  output logic             slow_mode,
  output logic             sr_req,
  input  logic             sr_ack,
  output logic             seq_done,
  output logic             rst_hold
);
  localparam int CW = (LOCK_CYC < 2) ? 1 : $clog2(LOCK_CYC);
  localparam logic [CW-1:0] CNT_LOAD = CW'(LOCK_CYC - 1);

  typedef enum logic [2:0] {S_IDLE, S_GATE, S_PROG, S_LOCK, S_SRX} st_t;

  st_t              st;
  logic [CFG_W-1:0] cfg_pend, seq_cfg;
  logic             seq_turbo, seq_slow, gpio_seen;
  logic [CW-1:0]    cnt;

  wire              start   = ctl_wr_en && ctl_fcs && (st == S_IDLE);
  wire [CFG_W-1:0]  cfg_nxt = cfg_wr_en ? cfg_wr_data : cfg_pend;
  wire              relock  = (st == S_GATE) || (st == S_PROG) || (st == S_LOCK);

  assign pll_prog   = (st == S_PROG);
  assign cpu_clk_en = (st == S_IDLE) || (st == S_SRX);
  assign irq_gate   = !cpu_clk_en;
  assign sr_req     = relock;
  assign rst_hold   = gpio_rst || gpio_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;  cfg_pend <= CFG_RST;  seq_cfg <= CFG_RST;  pll_cfg <= CFG_RST;
      seq_turbo <= 1'b0;  seq_slow <= 1'b0;  turbo_mode <= 1'b0;  slow_mode <= 1'b0;
      fcs_flag <= 1'b0;  seq_done <= 1'b0;  gpio_seen <= 1'b0;  cnt <= '0;
    end else if (wdt_rst) begin
      st <= S_IDLE;  cfg_pend <= CFG_RST;  seq_cfg <= CFG_RST;  pll_cfg <= CFG_RST;
      seq_turbo <= 1'b0;  seq_slow <= 1'b0;  turbo_mode <= 1'b0;  slow_mode <= 1'b0;
      fcs_flag <= 1'b0;  seq_done <= 1'b0;  gpio_seen <= 1'b0;  cnt <= '0;
    end else begin
      seq_done <= 1'b0;
      if (cfg_wr_en) cfg_pend <= cfg_wr_data;
      if (ctl_wr_en) fcs_flag <= ctl_fcs;
      if (gpio_rst && relock) gpio_seen <= 1'b1;
      unique case (st)
        S_IDLE: if (start) begin
          st        <= S_GATE;
          seq_cfg   <= cfg_nxt;
          seq_turbo <= ctl_turbo;
          seq_slow  <= ctl_slow;
        end
        S_GATE: if (sr_ack) begin
          st      <= S_PROG;
          pll_cfg <= seq_cfg;
          cnt     <= CNT_LOAD;
        end
        S_PROG: st <= S_LOCK;
        S_LOCK: if (cnt == '0) begin
          st         <= S_SRX;
          turbo_mode <= seq_turbo;
          slow_mode  <= seq_slow;
          gpio_seen  <= 1'b0;
        end else begin
          cnt <= cnt - 1'b1;
        end
        S_SRX: if (!sr_ack) begin
          st       <= S_IDLE;
          seq_done <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module freq_change_seq_chk #(
  parameter int CFG_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wdt_rst,
  input logic             gpio_rst,
  input logic             ctl_wr_en,
  input logic             fcs_flag,
  input logic             pll_prog,
  input logic [CFG_W-1:0] pll_cfg,
  input logic             cpu_clk_en,
  input logic             sr_req,
  input logic             sr_ack,
  input logic             seq_done,
  input logic             rst_hold
);
  AST_PROG_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    pll_prog |=> !pll_prog); // R4
  AST_PROG_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    pll_prog |-> (!cpu_clk_en && sr_req && $past(sr_ack))); // R3
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!pll_prog && !$past(wdt_rst)) |-> $stable(pll_cfg)); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !seq_done); // R6
  AST_DONE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> (cpu_clk_en && !sr_req)); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fcs_flag) && !$past(ctl_wr_en) && !$past(wdt_rst)) |-> fcs_flag); // R7
  AST_HOLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    gpio_rst |-> rst_hold); // R9
  AST_HOLD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk_en && !gpio_rst) |-> !rst_hold); // R9
endmodule

bind freq_change_seq freq_change_seq_chk #(.CFG_W(CFG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wdt_rst(wdt_rst), .gpio_rst(gpio_rst),
  .ctl_wr_en(ctl_wr_en), .fcs_flag(fcs_flag), .pll_prog(pll_prog),
  .pll_cfg(pll_cfg), .cpu_clk_en(cpu_clk_en), .sr_req(sr_req),
  .sr_ack(sr_ack), .seq_done(seq_done), .rst_hold(rst_hold)
);

// File: tb/test_freq_change_seq.sv
module test_freq_change_seq;
  localparam int         W    = 4;
  localparam logic [3:0] RSTV = 4'h5;
  localparam int         LOCK = 3;

  logic clk = 0, rst_n = 0, wdt_rst = 0, gpio_rst = 0;
  logic cfg_wr_en = 0, ctl_wr_en = 0, ctl_fcs = 0, ctl_turbo = 0, ctl_slow = 0;
  logic [W-1:0] cfg_wr_data = '0;
  logic fcs_flag, pll_prog, cpu_clk_en, irq_gate, turbo_mode, slow_mode, sr_req, seq_done, rst_hold;
  logic sr_ack = 0;
  logic [W-1:0] pll_cfg;
  int tests = 0, fails = 0, ack_dly = 0, ack_cnt = 0;
  bit done_all = 0;
  logic [W-1:0] cur_cfg = RSTV;
  bit cur_t = 0, cur_s = 0;

  always #5 clk = ~clk;

  freq_change_seq #(.CFG_W(W), .CFG_RST(RSTV), .LOCK_CYC(LOCK)) i_freq_change_seq (
    .clk(clk), .rst_n(rst_n), .wdt_rst(wdt_rst), .gpio_rst(gpio_rst),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data), .ctl_wr_en(ctl_wr_en),
    .ctl_fcs(ctl_fcs), .ctl_turbo(ctl_turbo), .ctl_slow(ctl_slow),
    .fcs_flag(fcs_flag), .pll_prog(pll_prog), .pll_cfg(pll_cfg),
    .cpu_clk_en(cpu_clk_en), .irq_gate(irq_gate), .turbo_mode(turbo_mode),
    .slow_mode(slow_mode), .sr_req(sr_req), .sr_ack(sr_ack),
    .seq_done(seq_done), .rst_hold(rst_hold));

  always @(negedge clk) begin
    if (sr_req != sr_ack) begin
      if (ack_cnt >= ack_dly) begin sr_ack = sr_req; ack_cnt = 0; end
      else ack_cnt++;
    end else ack_cnt = 0;
  end

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_reset_vals(input string req);
    chk({req, " pll_cfg"}, pll_cfg, RSTV);
    chk({req, " cpu_clk_en"}, cpu_clk_en, 1);
    chk({req, " irq_gate"}, irq_gate, 0);
    chk({req, " sr_req"}, sr_req, 0);
    chk({req, " fcs_flag"}, fcs_flag, 0);
    chk({req, " turbo"}, turbo_mode, 0);
    chk({req, " slow"}, slow_mode, 0);
    chk({req, " done"}, seq_done, 0);
    chk({req, " prog"}, pll_prog, 0);
  endtask

  // mode 0: plain, 1: writes during the sequence, 2: GPIO reset during the relock
  task automatic run_seq(input logic [W-1:0] c, input bit t, input bit s, input int dly, input int mode);
    int n, m, k, bad;
    ack_dly = dly;
    @(negedge clk) begin cfg_wr_en = 1; cfg_wr_data = c; end
    @(negedge clk) begin cfg_wr_en = 0; ctl_wr_en = 1; ctl_fcs = 1; ctl_turbo = t; ctl_slow = s; end
    @(negedge clk) ctl_wr_en = 0;
    chk("R3 clock stopped", cpu_clk_en, 0);
    chk("R3 irq gated", irq_gate, 1);
    chk("R3 self-refresh requested", sr_req, 1);
    n = 0;
    while (!pll_prog && n < 50) begin @(negedge clk); n++; end
    chk("R3 prog after ack", n, dly + 1);
    chk("R4 prog pulse", pll_prog, 1);
    chk("R4 programmed word", pll_cfg, c);
    chk("R2 mode held until restart", turbo_mode, cur_t);
    if (mode == 1) begin
      cfg_wr_en = 1; cfg_wr_data = ~c; ctl_wr_en = 1; ctl_fcs = 1; ctl_turbo = ~t; ctl_slow = ~s;
    end
    if (mode == 2) gpio_rst = 1;
    m = 0; bad = 0;
    do begin
      @(negedge clk); m++;
      cfg_wr_en = 0; ctl_wr_en = 0; gpio_rst = 0;
      if (!cpu_clk_en && mode == 2 && !rst_hold) bad++;
    end while (!cpu_clk_en && m < 50);
    chk("R5 lock length", m, LOCK + 1);
    chk("R5 turbo applied", turbo_mode, t);
    chk("R5 slow idle applied", slow_mode, s);
    chk("R5 irq ungated", irq_gate, 0);
    chk("R5 self-refresh released", sr_req, 0);
    if (mode == 1) chk("R2 word unchanged by mid-sequence write", pll_cfg, c);
    if (mode == 2) begin
      chk("R9 hold through relock", bad, 0);
      chk("R9 hold released at restart", rst_hold, 0);
    end
    k = 0;
    while (!seq_done && k < 50) begin @(negedge clk); k++; end
    chk("R6 done after ack drop", k, dly + 1);
    @(negedge clk);
    chk("R6 done one cycle", seq_done, 0);
    chk("R7 flag sticky", fcs_flag, 1);
    cur_cfg = c; cur_t = t; cur_s = s;
    if (mode == 1) begin
      repeat (6) @(negedge clk);
      chk("R10 no second sequence", sr_req, 0);
      chk("R10 clock still running", cpu_clk_en, 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_all) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_reset_vals("R1 in reset");
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk_reset_vals("R1 after release");

    @(negedge clk) begin cfg_wr_en = 1; cfg_wr_data = 4'hA; end
    @(negedge clk) cfg_wr_en = 0;
    repeat (3) @(negedge clk);
    chk("R2 write alone no effect", pll_cfg, RSTV);
    chk("R2 no sequence", sr_req, 0);

    @(negedge clk) begin ctl_wr_en = 1; ctl_fcs = 0; ctl_turbo = 1; ctl_slow = 1; end
    @(negedge clk) ctl_wr_en = 0;
    repeat (3) @(negedge clk);
    chk("R7 clear write no start", sr_req, 0);
    chk("R7 flag clear", fcs_flag, 0);
    chk("R7 turbo untouched", turbo_mode, 0);

    for (int c = 0; c < 16; c++)
      for (int md = 0; md < 4; md++)
        run_seq(W'(c), md[0], md[1], (c + md) % 3, 0);

    run_seq(cur_cfg, cur_t, cur_s, 1, 0);
    run_seq(4'h9, 1, 0, 2, 1);
    run_seq(4'h3, 0, 1, 0, 2);

    @(negedge clk) gpio_rst = 1;
    #1 chk("R9 hold follows gpio", rst_hold, 1);
    @(negedge clk) gpio_rst = 0;
    @(negedge clk) chk("R9 idle hold released", rst_hold, 0);

    @(negedge clk) begin cfg_wr_en = 1; cfg_wr_data = 4'hE; ctl_wr_en = 1; ctl_fcs = 1; ctl_turbo = 1; end
    @(negedge clk) begin cfg_wr_en = 0; ctl_wr_en = 0; end
    while (!pll_prog) @(negedge clk);
    @(negedge clk) wdt_rst = 1;
    @(negedge clk) wdt_rst = 0;
    chk_reset_vals("R8 watchdog abort");
    repeat (6) @(negedge clk);
    @(negedge clk) begin ctl_wr_en = 1; ctl_fcs = 1; ctl_turbo = 0; end
    @(negedge clk) ctl_wr_en = 0;
    while (!pll_prog) @(negedge clk);
    chk("R8 pending word reset", pll_cfg, RSTV);
    @(negedge clk) rst_n = 0;
    @(negedge clk) chk_reset_vals("R8 hardware abort");
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk("R8 stays idle", sr_req, 0);

    done_all = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule